// File: doc/BRIEF.md
# Addressable SPI Slave Front End

This block is the serial front end of a device meant to share one SPI bus with many identical copies of itself. The master always drives the serial clock and starts every transfer by pulling chip select low. Two selection schemes are available through a mode input. With hardware selection, chip select alone picks the device and the first byte is an opcode. With software selection, the first byte is a device address. It is checked against eight strap inputs, and only a matching device goes on to decode an opcode. A device that does not match stays silent until chip select rises and falls again.

Decoded opcodes go to an internal register file. A write opcode is followed by one data byte, which is handed over with a single-cycle strobe. A read opcode raises a request and then shifts out two bytes: a status byte and then a data byte. A no-operation opcode, like any other opcode that is neither read nor write, is only reported.

The serial inputs are brought into the system clock domain through two-flop synchronizers. The serial clock must therefore run at no more than a quarter of the system clock. Bits are taken on the rising edge of the serial clock and launched on the falling edge (SPI mode 0).

Top module: `addrSpiSlave`

## Requirements
- R1: After reset, soOe, wrStrobe, opValid and rdReq are all low.
- R2: With swAddrMode low, the first byte after chip select falls is taken as the opcode. It appears on opcode together with a one-cycle opValid pulse.
- R3: With swAddrMode high, the first byte (MSB first) is compared with devAddr[7:0]. On equality, the second byte is taken as the opcode.
- R4: On an address mismatch, the block produces no opValid, wrStrobe or rdReq pulse and keeps soOe low for the rest of that transaction. The next transaction, begun by chip select rising and falling again, is decoded normally.
- R5: After the read opcode 0x03, rdReq pulses for one cycle. The block then shifts out statusIn followed by rdData, each MSB first, and exactly as each stood when it was loaded.
- R6: After the write opcode 0x02, the next byte appears on wrData together with a one-cycle wrStrobe after its eighth bit.
- R7: The opcode 0x00 (no operation), and any opcode other than 0x02 or 0x03, produces opValid only: no rdReq, no wrStrobe, and soOe stays low.
- R8: soOe is high only while the status and data bytes of an addressed read are being sent. It is low whenever chip select is high.
- R9: Raising chip select in the middle of a byte aborts the transaction. The partial byte has no effect, and the bit count restarts at zero for the next transaction.
- R10: The block samples input bits on the rising edge of sck and changes output bits on the falling edge of sck, so a master that samples soData just before each rising edge reads the correct bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data in |
| soData | output | 1 | Serial data out, valid when soOe is high |
| soOe | output | 1 | Output enable for the serial-out pad driver |
| devAddr | input | 8 | Device address straps |
| swAddrMode | input | 1 | 1 = address byte leads, 0 = chip select selects |
| opcode | output | 8 | Last decoded opcode |
| opValid | output | 1 | One-cycle pulse when opcode updates |
| wrData | output | 8 | Write data byte |
| wrStrobe | output | 1 | One-cycle write strobe |
| rdReq | output | 1 | One-cycle read request |
| statusIn | input | 8 | Status byte from the register file |
| rdData | input | 8 | Read data from the register file |

## Verification
The bench sends an address that differs from the straps in only its last bit. A design that compared too few bits, or ignored the outcome of the comparison, would then accept the following write. It aborts a write partway through a data byte and then sends a clean write. A bit counter that was not cleared would frame the second byte wrongly, and a design without the abort would raise a stray strobe. Read checks use asymmetric status and data patterns, so a design that was off by one in the output shift, or launched bits on the wrong edge, would return shifted or swapped bytes. A no-operation opcode and an unassigned opcode confirm that neither request nor output enable leaks out.

// File: rtl/addrSpiPkg.sv
package addrSpiPkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_OPC, S_WDATA, S_RSTAT, S_RDATA, S_DONE, S_STANDBY
  } spiState_e;

  typedef struct packed {
    logic clrCnt;    // hold bit counter at zero
    logic loadStat;  // load status byte into output shifter
    logic loadData;  // load read data into output shifter
    logic shiftOut;  // shift output on serial clock falling edge
  } spiStrobe_t;
endpackage

// File: rtl/addrSpiDatapath.sv
module addrSpiDatapath
  import addrSpiPkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csN,
  input  logic          sck,
  input  logic          si,
  input  spiStrobe_t    strb,
  input  logic [DW-1:0] statusIn,
  input  logic [DW-1:0] rdData,
  output logic          csHigh,
  output logic          csFall,
  output logic          byteDone,
  output logic [DW-1:0] rxByte,
  output logic          soBit
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  logic [SYNC_STAGES-1:0] csSync, sckSync, siSync;
  logic csPrev, sckPrev;
  logic csNow, sckNow, siNow, sckRise, sckFall;
  logic [CW-1:0] bitCnt;
  logic [DW-1:0] shiftIn, outReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync  <= '1;
      sckSync <= '0;
      siSync  <= '0;
      csPrev  <= 1'b1;
      sckPrev <= 1'b0;
    end else begin
      csSync  <= {csSync[SYNC_STAGES-2:0], csN};
      sckSync <= {sckSync[SYNC_STAGES-2:0], sck};
      siSync  <= {siSync[SYNC_STAGES-2:0], si};
      csPrev  <= csNow;
      sckPrev <= sckNow;
    end
  end

  assign csNow   = csSync[SYNC_STAGES-1];
  assign sckNow  = sckSync[SYNC_STAGES-1];
  assign siNow   = siSync[SYNC_STAGES-1];
  assign csHigh  = csNow;
  assign csFall  = csPrev & ~csNow;
  assign sckRise = sckNow & ~sckPrev;
  assign sckFall = ~sckNow & sckPrev;

  // receive shifter and bit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      shiftIn <= '0;
    end else if (strb.clrCnt) begin
      bitCnt  <= '0;
    end else if (sckRise) begin
      shiftIn <= {shiftIn[DW-2:0], siNow};
      bitCnt  <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
    end
  end

  assign rxByte   = {shiftIn[DW-2:0], siNow};
  assign byteDone = sckRise && (bitCnt == LAST_BIT) && !csNow;

  // transmit shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= '0;
      soBit  <= 1'b0;
    end else if (strb.loadStat) begin
      outReg <= statusIn;
    end else if (strb.loadData) begin
      outReg <= rdData;
    end else if (strb.shiftOut && sckFall) begin
      soBit  <= outReg[DW-1];
      outReg <= {outReg[DW-2:0], 1'b0};
    end
  end

  // R9: while chip select is high the bit counter is held at zero
  a_r9_cnt_cleared: assert property (@(posedge clk) disable iff (!rstN)
    csHigh |=> (bitCnt == '0));
  // R10: output bit moves only on a synchronized falling edge of sck
  a_r10_so_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (soBit != $past(soBit)) |-> $past(sckFall));
endmodule

// File: rtl/addrSpiCtrl.sv
module addrSpiCtrl
  import addrSpiPkg::*;
#(
  parameter int          DW        = 8,
  parameter logic [DW-1:0] OPC_READ  = 8'h03,
  parameter logic [DW-1:0] OPC_WRITE = 8'h02
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csHigh,
  input  logic          csFall,
  input  logic          byteDone,
  input  logic [DW-1:0] rxByte,
  input  logic [DW-1:0] devAddr,
  input  logic          swAddrMode,
  output spiStrobe_t    strb,
  output logic          soOe,
  output logic [DW-1:0] opcode,
  output logic          opValid,
  output logic [DW-1:0] wrData,
  output logic          wrStrobe,
  output logic          rdReq
);
  spiState_e state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      opcode   <= '0;
      opValid  <= 1'b0;
      wrData   <= '0;
      wrStrobe <= 1'b0;
      rdReq    <= 1'b0;
    end else begin
      opValid  <= 1'b0;
      wrStrobe <= 1'b0;
      rdReq    <= 1'b0;
      if (csHigh) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_IDLE:  if (csFall) state <= swAddrMode ? S_ADDR : S_OPC;
          S_ADDR:  if (byteDone) state <= (rxByte == devAddr) ? S_OPC : S_STANDBY;
          S_OPC: if (byteDone) begin
            opcode  <= rxByte;
            opValid <= 1'b1;
            if (rxByte == OPC_READ) begin
              rdReq <= 1'b1;
              state <= S_RSTAT;
            end else if (rxByte == OPC_WRITE) begin
              state <= S_WDATA;
            end else begin
              state <= S_DONE;
            end
          end
          S_WDATA: if (byteDone) begin
            wrData   <= rxByte;
            wrStrobe <= 1'b1;
            state    <= S_DONE;
          end
          S_RSTAT: if (byteDone) state <= S_RDATA;
          S_RDATA: if (byteDone) state <= S_DONE;
          default: state <= state;
        endcase
      end
    end
  end

  always_comb begin
    strb.clrCnt   = csHigh;
    strb.loadStat = (state == S_OPC) && byteDone && !csHigh && (rxByte == OPC_READ);
    strb.loadData = (state == S_RSTAT) && byteDone && !csHigh;
    strb.shiftOut = (state == S_RSTAT) || (state == S_RDATA);
  end

  assign soOe = (state == S_RSTAT) || (state == S_RDATA);

  a_r6_wr_single: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);
  a_r5_rdreq_single: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq);
  a_r8_oe_drops: assert property (@(posedge clk) disable iff (!rstN)
    csHigh |=> !soOe);
  a_r4_standby_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_STANDBY && !csHigh) |=> (state == S_STANDBY) && !opValid && !wrStrobe && !rdReq);
  a_r2_opvalid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> !opValid);
endmodule

// File: rtl/addrSpiSlave.sv
module addrSpiSlave
  import addrSpiPkg::*;
#(
  parameter int            DW          = 8,
  parameter int            SYNC_STAGES = 2,
  parameter logic [DW-1:0] OPC_READ    = 8'h03,
  parameter logic [DW-1:0] OPC_WRITE   = 8'h02
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csN,
  input  logic          sck,
  input  logic          si,
  output logic          soData,
  output logic          soOe,
  input  logic [DW-1:0] devAddr,
  input  logic          swAddrMode,
  output logic [DW-1:0] opcode,
  output logic          opValid,
  output logic [DW-1:0] wrData,
  output logic          wrStrobe,
  output logic          rdReq,
  input  logic [DW-1:0] statusIn,
  input  logic [DW-1:0] rdData
);
  spiStrobe_t    strb;
  logic          csHigh, csFall, byteDone, soBit;
  logic [DW-1:0] rxByte;

  addrSpiDatapath #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si),
    .strb(strb), .statusIn(statusIn), .rdData(rdData),
    .csHigh(csHigh), .csFall(csFall), .byteDone(byteDone),
    .rxByte(rxByte), .soBit(soBit)
  );

  addrSpiCtrl #(.DW(DW), .OPC_READ(OPC_READ), .OPC_WRITE(OPC_WRITE)) i_ctrl (
    .clk(clk), .rstN(rstN), .csHigh(csHigh), .csFall(csFall),
    .byteDone(byteDone), .rxByte(rxByte), .devAddr(devAddr),
    .swAddrMode(swAddrMode), .strb(strb), .soOe(soOe),
    .opcode(opcode), .opValid(opValid), .wrData(wrData),
    .wrStrobe(wrStrobe), .rdReq(rdReq)
  );

  assign soData = soOe ? soBit : 1'b0;
endmodule

// File: tb/test_addrSpiSlave.sv
`timescale 1ns/1ps
module test_addrSpiSlave;
  localparam int HALF = 6;  // system clocks per serial half period

  logic clk = 1'b0, rstN = 1'b0;
  logic csN = 1'b1, sck = 1'b0, si = 1'b0;
  logic soData, soOe, swAddrMode = 1'b0;
  logic [7:0] devAddr = 8'h5A, opcode, wrData, statusIn = 8'h00, rdData = 8'h00;
  logic opValid, wrStrobe, rdReq;

  int checks = 0, errors = 0;
  int wrCnt = 0, opCnt = 0, rdCnt = 0, oeCnt = 0;
  logic [7:0] lastWr = 8'h00, lastOp = 8'h00;
  bit done = 1'b0;

  always #2 clk = ~clk;

  addrSpiSlave i_addrSpiSlave (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si),
    .soData(soData), .soOe(soOe), .devAddr(devAddr), .swAddrMode(swAddrMode),
    .opcode(opcode), .opValid(opValid), .wrData(wrData), .wrStrobe(wrStrobe),
    .rdReq(rdReq), .statusIn(statusIn), .rdData(rdData)
  );

  always @(posedge clk) begin
    if (wrStrobe) begin wrCnt <= wrCnt + 1; lastWr <= wrData; end
    if (opValid)  begin opCnt <= opCnt + 1; lastOp <= opcode; end
    if (rdReq)    rdCnt <= rdCnt + 1;
    if (soOe)     oeCnt <= oeCnt + 1;
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sendBits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - n; i--) begin
      si = tx[i];
      waitClk(HALF);
      rx[i] = soData;
      sck = 1'b1;
      waitClk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    sendBits(tx, 8, rx);
  endtask

  task automatic csLow();
    csN = 1'b0;
    waitClk(HALF);
  endtask

  task automatic csHighT();
    waitClk(HALF);
    csN = 1'b1;
    waitClk(2 * HALF);
  endtask

  task automatic testReset();
    chk("R1 soOe", int'(soOe), 0);
    chk("R1 wrStrobe", int'(wrStrobe), 0);
    chk("R1 opValid", int'(opValid), 0);
    chk("R1 rdReq", int'(rdReq), 0);
  endtask

  task automatic testHwWrite();
    int w0 = wrCnt, o0 = opCnt, r0 = rdCnt, e0 = oeCnt;
    logic [7:0] rx;
    swAddrMode = 1'b0;
    csLow();
    xfer(8'h02, rx);
    xfer(8'hA5, rx);
    csHighT();
    chk("R2 opValid count", opCnt - o0, 1);
    chk("R2 opcode", int'(lastOp), 'h02);
    chk("R6 wrStrobe count", wrCnt - w0, 1);
    chk("R6 wrData", int'(lastWr), 'hA5);
    chk("R6 no rdReq", rdCnt - r0, 0);
    chk("R8 soOe low on write", oeCnt - e0, 0);
  endtask

  task automatic testRead(input bit sw, input logic [7:0] st, input logic [7:0] dt);
    int r0 = rdCnt, e0 = oeCnt, w0 = wrCnt;
    logic [7:0] rx, rs, rd;
    swAddrMode = sw;
    statusIn = st;
    rdData = dt;
    csLow();
    if (sw) xfer(devAddr, rx);
    xfer(8'h03, rx);
    xfer(8'h00, rs);
    xfer(8'hFF, rd);
    csHighT();
    chk(sw ? "R3 status byte" : "R5 status byte", int'(rs), int'(st));
    chk("R10 data byte", int'(rd), int'(dt));
    chk("R5 rdReq count", rdCnt - r0, 1);
    chk("R5 no wrStrobe", wrCnt - w0, 0);
    chk("R8 soOe during read", int'(oeCnt - e0 > 0), 1);
    chk("R8 soOe low after cs", int'(soOe), 0);
  endtask

  task automatic testMismatch();
    int w0 = wrCnt, o0 = opCnt, r0 = rdCnt, e0 = oeCnt;
    logic [7:0] rx;
    swAddrMode = 1'b1;
    devAddr = 8'h5A;
    csLow();
    xfer(8'h5B, rx);
    xfer(8'h02, rx);
    xfer(8'h11, rx);
    xfer(8'h03, rx);
    csHighT();
    chk("R4 no opValid", opCnt - o0, 0);
    chk("R4 no wrStrobe", wrCnt - w0, 0);
    chk("R4 no rdReq", rdCnt - r0, 0);
    chk("R4 soOe stays low", oeCnt - e0, 0);
    csLow();
    xfer(8'h5A, rx);
    xfer(8'h02, rx);
    xfer(8'h66, rx);
    csHighT();
    chk("R3 matched write count", wrCnt - w0, 1);
    chk("R4 reselect wrData", int'(lastWr), 'h66);
  endtask

  task automatic testAbort();
    int w0 = wrCnt;
    logic [7:0] rx;
    swAddrMode = 1'b0;
    csLow();
    xfer(8'h02, rx);
    sendBits(8'hF0, 4, rx);
    csHighT();
    chk("R9 aborted write", wrCnt - w0, 0);
    csLow();
    xfer(8'h02, rx);
    xfer(8'h3C, rx);
    csHighT();
    chk("R9 write after abort count", wrCnt - w0, 1);
    chk("R9 write after abort data", int'(lastWr), 'h3C);
  endtask

  task automatic testNop(input logic [7:0] op);
    int w0 = wrCnt, o0 = opCnt, r0 = rdCnt, e0 = oeCnt;
    logic [7:0] rx;
    swAddrMode = 1'b0;
    csLow();
    xfer(op, rx);
    xfer(8'h55, rx);
    csHighT();
    chk("R7 opValid", opCnt - o0, 1);
    chk("R7 opcode", int'(lastOp), int'(op));
    chk("R7 no wrStrobe", wrCnt - w0, 0);
    chk("R7 no rdReq", rdCnt - r0, 0);
    chk("R7 soOe low", oeCnt - e0, 0);
  endtask

  initial begin
    waitClk(5);
    testReset();
    rstN = 1'b1;
    waitClk(5);
    testReset();
    testHwWrite();
    testRead(1'b0, 8'h3C, 8'hC3);
    testRead(1'b1, 8'h81, 8'h7E);
    testMismatch();
    testAbort();
    testNop(8'h00);
    testNop(8'h7F);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule